// File: doc/BRIEF.md
# Command-Controlled Interval Watchdog Timer

This block is a 32-bit down-counting interval timer driven through a small 16-bit register bus. Software starts and halts it with two command bits. It sees the count as a low half and a high half. It can load either half at any time. The count falls by one on every pulse of a tick-enable input. In the intended system that input pulses once every 200 ns, which gives a 5 MHz count rate.

When the count is zero and a tick arrives, the counter wraps to all ones and keeps counting. At the same time it sets an underflow flag in a status register. The status register is cleared by writing ones to it. A mask register selects which status bits drive the interrupt output. The interrupt is high while any masked status bit is set. All bus pins and the interrupt are plain control signals with no handshake. A write lands at the rising clock edge where the write strobe is high. Reads are combinational from the address, so a count read returns the value of the current cycle.

Top module: `iwdt_top`

## Requirements
- R1: After reset the timer is halted. The command register (address 0) reads 0x0010, which means the stop bit 4 is set and the start bit 5 is clear. The count, mask and status all read 0, and the interrupt is low.
- R2: Writing the command register with bit 5 (0x0020) set and bit 4 clear starts the timer and clears the stop bit. While it runs, the count falls by exactly one for each clock cycle in which the tick-enable input is high.
- R3: Writing the command register with bit 4 (0x0010) set halts the timer and clears the start bit. The count then stays frozen, whatever ticks arrive, until the next write.
- R4: A command write that has both bit 5 and bit 4 set halts the timer. The command register then reads 0x0010.
- R5: The count is {high half, low half}. The low half is at address 1 and the high half is at address 2. Decrements borrow from the low half into the high half, and reads return the count of the current cycle.
- R6: A write to address 1 replaces the low half and a write to address 2 replaces the high half. The write wins over a tick in the same cycle, and counting continues from the new value.
- R7: A tick while the count is zero and running reloads the count to 0xFFFF_FFFF. It also sets status bit 7 (0x0080) at address 4, and counting continues downward from the new value.
- R8: The interrupt output is high exactly when the mask register (address 3) ANDed with the status register is nonzero.
- R9: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If an underflow happens in the same cycle as the clear, the underflow wins.
- R10: Mask bit 15 cannot be written and always reads 0. Reads of unmapped addresses (5 to 7) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle count pulse (once per 200 ns in the system) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong run flag shows on the next tick. The count either moves while it should be frozen or stays still while it should fall, so it is checked one tick after every start, stop and combined command. A lost borrow or a bad wrap shows in the first read after the tick that crosses the half boundary or leaves zero. The bench therefore reads both halves right after such ticks. A status flag that is set or cleared wrongly shows on the interrupt pin in the same cycle. So the interrupt pin is sampled after underflow, after mask changes, after a write of 0 to status and after a write of 1 to status.

// File: rtl/iwdt_pkg.sv
package iwdt_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] ADDR_CMD    = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_CNT_LO = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_CNT_HI = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_MASK   = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_STAT   = 3'd4;
  localparam int CMD_STOP_BIT  = 4;
  localparam int CMD_START_BIT = 5;
  localparam int STAT_UF_BIT   = 7;
  localparam int MASK_RO_BIT   = 15;
endpackage

// File: rtl/iwdt_cmd.sv
module iwdt_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o,
  output logic stop_o
);
  logic run_q, stop_q;

  // stop has priority over start when both are requested
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      stop_q <= 1'b1;
    end else if (wr_i && stop_i) begin
      run_q  <= 1'b0;
      stop_q <= 1'b1;
    end else if (wr_i && start_i) begin
      run_q  <= 1'b1;
      stop_q <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign stop_o = stop_q;

  a_r4_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && stop_i) |=> (!run_q && stop_q));
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && start_i && !stop_i) |=> (run_q && !stop_q));
endmodule

// File: rtl/iwdt_count.sv
module iwdt_count #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic                  tick_i,
  input  logic [1:0]            wr_half_i,
  input  logic [HALF_W-1:0]     wdata_i,
  output logic [2*HALF_W-1:0]   cnt_o,
  output logic                  uf_o
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] loaded;
  logic             any_wr, step;

  // per-half load path: the written half replaces, the other is kept
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign loaded[h*HALF_W +: HALF_W] =
      wr_half_i[h] ? wdata_i : cnt_q[h*HALF_W +: HALF_W];
  end

  assign any_wr = |wr_half_i;
  assign step   = run_i && tick_i && !any_wr;
  assign uf_o   = step && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (any_wr)     cnt_d = loaded;
    else if (uf_o)  cnt_d = '1;
    else if (step)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r7_wrap_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !any_wr && cnt_q == '0) |=> (cnt_q == {CNT_W{1'b1}}));
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !any_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !any_wr) |=> $stable(cnt_q));
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_half_i[0] |=> (cnt_q[HALF_W-1:0] == $past(wdata_i)));
endmodule

// File: rtl/iwdt_irq.sv
module iwdt_irq #(
  parameter int DATA_W = 16,
  parameter int UF_BIT = 7,
  parameter int RO_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr_i,
  input  logic              stat_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              uf_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] UF_VEC = DATA_W'(1) << UF_BIT;
  localparam logic [DATA_W-1:0] WR_KEEP = ~(DATA_W'(1) << RO_BIT);

  logic [DATA_W-1:0] mask_q, stat_q, clr_vec, set_vec;

  assign clr_vec = stat_wr_i ? wdata_i : '0;
  assign set_vec = uf_i ? UF_VEC : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_wr_i) mask_q <= wdata_i & WR_KEEP;
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = |(mask_q & stat_q);

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    uf_i |=> stat_q[UF_BIT]);
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && wdata_i[UF_BIT] && !uf_i) |=> !stat_q[UF_BIT]);
  a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[UF_BIT] && !(stat_wr_i && wdata_i[UF_BIT])) |=> stat_q[UF_BIT]);
endmodule

// File: rtl/iwdt_top.sv
module iwdt_top
  import iwdt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic              run, stopped, uf;
  logic [1:0]        wr_half;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] mask, stat;

  assign wr_half[0] = reg_wr && (reg_addr == ADDR_CNT_LO);
  assign wr_half[1] = reg_wr && (reg_addr == ADDR_CNT_HI);

  iwdt_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr && (reg_addr == ADDR_CMD)),
    .start_i (reg_wdata[CMD_START_BIT]),
    .stop_i  (reg_wdata[CMD_STOP_BIT]),
    .run_o   (run),
    .stop_o  (stopped)
  );

  iwdt_count #(.HALF_W(DATA_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .tick_i    (tick_en),
    .wr_half_i (wr_half),
    .wdata_i   (reg_wdata),
    .cnt_o     (cnt),
    .uf_o      (uf)
  );

  iwdt_irq #(.DATA_W(DATA_W), .UF_BIT(STAT_UF_BIT), .RO_BIT(MASK_RO_BIT)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr_i (reg_wr && (reg_addr == ADDR_MASK)),
    .stat_wr_i (reg_wr && (reg_addr == ADDR_STAT)),
    .wdata_i   (reg_wdata),
    .uf_i      (uf),
    .mask_o    (mask),
    .stat_o    (stat),
    .irq_o     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CMD: begin
        reg_rdata[CMD_START_BIT] = run;
        reg_rdata[CMD_STOP_BIT]  = stopped;
      end
      ADDR_CNT_LO: reg_rdata = cnt[DATA_W-1:0];
      ADDR_CNT_HI: reg_rdata = cnt[CNT_W-1:DATA_W];
      ADDR_MASK:   reg_rdata = mask;
      ADDR_STAT:   reg_rdata = stat;
      default:     reg_rdata = '0;
    endcase
  end

  a_r3_run_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && stopped));
  a_r10_mask_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_MASK) |-> !reg_rdata[MASK_RO_BIT]);
endmodule

// File: tb/iwdt_top_tb_top.sv
module iwdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 20;
  localparam int MAX_CYCLES = 200000;

  typedef struct packed {
    logic [31:0] load;
    logic [7:0]  ticks;
    logic [31:0] exp;
    logic        uf;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{32'h0000_0064, 8'd3, 32'h0000_0061, 1'b0},
    '{32'h0001_0000, 8'd1, 32'h0000_FFFF, 1'b0},
    '{32'h0000_0002, 8'd2, 32'h0000_0000, 1'b0},
    '{32'h0000_0001, 8'd2, 32'hFFFF_FFFF, 1'b1},
    '{32'h1234_0005, 8'd5, 32'h1234_0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int div_cnt = 0;

  iwdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    div_cnt <= (div_cnt == TICK_DIV-1) ? 0 : div_cnt + 1;
    tick_en <= (div_cnt == TICK_DIV-1);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > MAX_CYCLES) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, MAX_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic read_count(output logic [31:0] c);
    logic [15:0] lo, hi;
    bus_read(3'd1, lo);
    bus_read(3'd2, hi);
    c = {hi, lo};
  endtask

  task automatic wait_ticks(int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick_en) @(posedge clk);
    end
  endtask

  initial begin
    logic [15:0] d;
    logic [31:0] c;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_read(3'd0, d); check("R1 cmd after reset", 32'(d), 32'h0010);
    read_count(c);     check("R1 count after reset", c, 32'h0);
    bus_read(3'd3, d); check("R1 mask after reset", 32'(d), 32'h0);
    bus_read(3'd4, d); check("R1 status after reset", 32'(d), 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 halted: ticks do not move count
    wait_ticks(2);
    read_count(c); check("R1 halted out of reset", c, 32'h0);

    // vector table: R2 R5 R7
    foreach (VEC[i]) begin
      bus_write(3'd0, 16'h0010);
      bus_write(3'd2, VEC[i].load[31:16]);
      bus_write(3'd1, VEC[i].load[15:0]);
      bus_write(3'd0, 16'h0020);
      wait_ticks(int'(VEC[i].ticks));
      read_count(c);
      check($sformatf("R2 R5 R7 vector %0d count", i), c, VEC[i].exp);
      bus_read(3'd4, d);
      check($sformatf("R7 vector %0d status", i), 32'(d), VEC[i].uf ? 32'h0080 : 32'h0);
      bus_write(3'd4, 16'hFFFF);
    end

    // R2 start readback, R3 stop freezes
    bus_write(3'd0, 16'h0010);
    bus_write(3'd2, 16'h0000);
    bus_write(3'd1, 16'd50);
    bus_write(3'd0, 16'h0020);
    bus_read(3'd0, d); check("R2 cmd reads start", 32'(d), 32'h0020);
    wait_ticks(2);
    read_count(c); check("R2 two ticks", c, 32'd48);
    // R6 low-half write mid-run
    bus_write(3'd1, 16'd10);
    wait_ticks(1);
    read_count(c); check("R6 low write restarts", c, 32'd9);
    bus_write(3'd2, 16'h0002);
    wait_ticks(1);
    read_count(c); check("R6 high write restarts", c, 32'h0002_0008);
    bus_write(3'd0, 16'h0010);
    bus_read(3'd0, d); check("R3 cmd reads stop", 32'(d), 32'h0010);
    read_count(c);
    wait_ticks(3);
    begin
      logic [31:0] c2;
      read_count(c2); check("R3 frozen after stop", c2, c);
    end

    // R4 both bits: stop wins
    bus_write(3'd0, 16'h0020);
    bus_write(3'd0, 16'h0030);
    bus_read(3'd0, d); check("R4 both bits cmd", 32'(d), 32'h0010);
    read_count(c);
    wait_ticks(2);
    begin
      logic [31:0] c2;
      read_count(c2); check("R4 frozen after both bits", c2, c);
    end

    // R10 mask msb and unmapped reads
    bus_write(3'd3, 16'hFFFF);
    bus_read(3'd3, d); check("R10 mask msb reads 0", 32'(d), 32'h7FFF);
    bus_read(3'd6, d); check("R10 unmapped reads 0", 32'(d), 32'h0);

    // R7 R8 R9 underflow, irq, clearing
    bus_write(3'd3, 16'h0000);
    bus_write(3'd2, 16'h0000);
    bus_write(3'd1, 16'h0000);
    bus_write(3'd0, 16'h0020);
    wait_ticks(1);
    @(negedge clk);
    check("R8 irq masked off", 32'(irq), 32'h0);
    bus_read(3'd4, d); check("R7 flag on underflow", 32'(d), 32'h0080);
    wait_ticks(1);
    read_count(c); check("R7 continues after wrap", c, 32'hFFFF_FFFE);
    bus_write(3'd3, 16'h0080);
    check("R8 irq when masked in", 32'(irq), 32'h1);
    bus_write(3'd4, 16'h0000);
    check("R9 write 0 keeps flag irq", 32'(irq), 32'h1);
    bus_read(3'd4, d); check("R9 write 0 keeps flag", 32'(d), 32'h0080);
    bus_write(3'd4, 16'h0080);
    bus_read(3'd4, d); check("R9 write 1 clears", 32'(d), 32'h0);
    check("R8 irq drops after clear", 32'(irq), 32'h0);
    bus_write(3'd0, 16'h0010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule